// File: doc/BRIEF.md
# Non-Preemptive Fixed-Priority Arbiter

This block shares one resource among `N` requesters (four by default). Each requester holds its request line high for the whole time it uses the resource. The arbiter drives a grant vector in which at most one bit is high. The grant comes from a registered state machine. It has an idle state and one held state for each requester, so the grant for a request sampled on a clock edge shows on `gnt` just after that edge.

A choice is made only when the resource is free. The resource is free either because the machine is idle or because the current owner has just dropped its request. At that point the lowest-indexed pending requester wins, so requester 0 ranks highest. Once a grant is given it is never taken away while its owner keeps requesting, even if a higher-ranked request arrives. When the owner releases, the hand-over to the next pending requester happens on the same edge that sees the release, with no idle cycle in between.

Top module: `fp_hold_arbiter`

## Requirements
- R1: A clock edge with `rst_n` low puts the arbiter in its idle state, and `gnt` reads all zeros after that edge.
- R2: `gnt` has at most one bit set in every cycle.
- R3: From idle, an edge that samples a nonzero `req` makes `gnt` one-hot after that edge, at the bit position of the lowest-indexed set bit of `req`.
- R4: From idle, an edge that samples `req` all zeros leaves `gnt` all zeros.
- R5: While requester i holds the grant and `req[i]` is still high at an edge, `gnt[i]` stays high after that edge, whatever the other request bits are.
- R6: When the owner's request bit is low at an edge and some other request bit is high, `gnt` moves after that same edge to the lowest-indexed high request bit, with no all-zero cycle in between.
- R7: When the owner's request bit is low at an edge and no request bit is high, `gnt` is all zeros after that edge.
- R8: `gnt[i]` is never high right after an edge that sampled `req[i]` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req | input | N | One request line per requester; bit 0 has the highest rank |
| gnt | output | N | Grant vector, one-hot or all zeros, decoded from registered state |

## Verification
Each result is due one rising edge after the request pattern that causes it. The grant decode from the state register is purely combinational, so `gnt` is stable well before the next falling edge. The bench therefore drives `req` on a falling edge and lets one rising edge pass. It updates its arithmetic model just after that edge and compares `gnt` at the following falling edge, before it changes `req` again. Reset is checked the same way: the comparison waits one falling edge after an edge with `rst_n` low.

// File: rtl/fpa_pkg.sv
// Package: fpa_pkg
// Shared types and helpers for the fixed-priority hold arbiter.
// Assumes nothing about the requester count; widths are derived by users.
package fpa_pkg;

    // Phase of the arbiter state machine: free, or held by the recorded owner.
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_HELD = 1'b1
    } phase_e;

    // Width of an index into n requesters, never below one bit.
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/prio_pick.sv
// Module: prio_pick
// Combinational fixed-priority selector: reports whether any candidate bit is
// set and the index of the lowest set bit (bit 0 ranks highest).
// Assumes IW is wide enough to hold N-1.
module prio_pick #(
    parameter int N  = 4,
    parameter int IW = fpa_pkg::idx_width(N)
) (
    input  logic [N-1:0]  cand,
    output logic          any,
    output logic [IW-1:0] win
);

    // Scan from the top so the lowest set index is the last one written.
    always_comb begin
        any = |cand;
        win = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                win = IW'(i);
            end
        end
    end

endmodule

// File: rtl/arb_state.sv
// Module: arb_state
// State register of the arbiter: phase plus owner index. It moves to a new
// owner only when free (idle, or when the owner's request has dropped).
// Assumes pick_any/pick_idx come from a priority scan of the same req vector.
module arb_state #(
    parameter int N  = 4,
    parameter int IW = fpa_pkg::idx_width(N)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N-1:0]    req,
    input  logic            pick_any,
    input  logic [IW-1:0]   pick_idx,
    output fpa_pkg::phase_e phase_q,
    output logic [IW-1:0]   owner_q
);
    import fpa_pkg::*;

    phase_e        phase_d;
    logic [IW-1:0] owner_d;
    logic          owner_keeps;

    // Owner still requesting: the grant must not move.
    assign owner_keeps = req[owner_q];

    // Next-state choice: hold while the owner keeps requesting, otherwise re-pick.
    always_comb begin
        phase_d = phase_q;
        owner_d = owner_q;
        case (phase_q)
            PH_IDLE: begin
                if (pick_any) begin
                    phase_d = PH_HELD;
                    owner_d = pick_idx;
                end
            end
            PH_HELD: begin
                if (!owner_keeps) begin
                    if (pick_any) begin
                        owner_d = pick_idx;
                    end else begin
                        phase_d = PH_IDLE;
                        owner_d = '0;
                    end
                end
            end
            default: begin
                phase_d = PH_IDLE;
                owner_d = '0;
            end
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            owner_q <= '0;
        end else begin
            phase_q <= phase_d;
            owner_q <= owner_d;
        end
    end

endmodule

// File: rtl/grant_decode.sv
// Module: grant_decode
// Turns the registered phase and owner index into a one-hot-or-zero vector.
// Assumes owner < N whenever the phase is held.
module grant_decode #(
    parameter int N  = 4,
    parameter int IW = fpa_pkg::idx_width(N)
) (
    input  fpa_pkg::phase_e phase,
    input  logic [IW-1:0]   owner,
    output logic [N-1:0]    gnt
);
    import fpa_pkg::*;

    // One comparator per requester line.
    for (genvar g = 0; g < N; g++) begin : g_line
        assign gnt[g] = (phase == PH_HELD) && (owner == IW'(g));
    end

endmodule

// File: rtl/fp_hold_arbiter.sv
// Module: fp_hold_arbiter
// Non-preemptive fixed-priority arbiter for N requesters. A grant lasts until
// its owner drops its request; priority (lowest index wins) applies only when
// the resource is free. The grant follows the sampling edge by one clock.
// Assumes requesters keep req high for the whole use of the resource.
module fp_hold_arbiter #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    import fpa_pkg::*;

    localparam int IW = idx_width(N);

    logic          pick_any;
    logic [IW-1:0] pick_idx;
    phase_e        phase_q;
    logic [IW-1:0] owner_q;

    prio_pick #(.N(N), .IW(IW)) u_pick (
        .cand (req),
        .any  (pick_any),
        .win  (pick_idx)
    );

    arb_state #(.N(N), .IW(IW)) u_state (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .pick_any (pick_any),
        .pick_idx (pick_idx),
        .phase_q  (phase_q),
        .owner_q  (owner_q)
    );

    grant_decode #(.N(N), .IW(IW)) u_dec (
        .phase (phase_q),
        .owner (owner_q),
        .gnt   (gnt)
    );

    // Lowest set request bit by two's-complement isolation, for the checks only.
    logic [N-1:0] req_low;
    assign req_low = req & (~req + 1'b1);

    // R1: reset always leaves the grant vector empty.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (gnt == '0));

    // R2: never more than one grant.
    assert_onehot0_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R3: from idle, the lowest pending request wins.
    assert_idle_pick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && (req != '0)) |=> (gnt == $past(req_low)));

    // R4: idle with no requests stays idle.
    assert_idle_stay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt == '0) && (req == '0)) |=> (gnt == '0));

    // R6: released resource passes straight to the lowest pending request.
    assert_handover_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && ((gnt & req) == '0) && (req != '0)) |=> (gnt == $past(req_low)));

    // R7: released resource with nobody waiting goes idle.
    assert_release_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((gnt != '0) && (req == '0)) |=> (gnt == '0));

    for (genvar a = 0; a < N; a++) begin : g_chk
        // R5: an owner that keeps requesting keeps its grant.
        assert_no_preempt_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (gnt[a] && req[a]) |=> gnt[a]);

        // R8: no grant to a line that was not requesting.
        assert_grant_needs_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
            !req[a] |=> !gnt[a]);
    end

endmodule

// File: tb/fp_hold_arbiter_tb.sv
`timescale 1ns/1ps
module fp_hold_arbiter_tb;

    localparam int N = 4;

    logic         clk   = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req   = '0;
    wire  [N-1:0] gnt;

    int checks   = 0;
    int failures = 0;
    int model    = -1;   // -1: idle, else owner index
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    fp_hold_arbiter #(.N(N)) u_dut (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .gnt   (gnt)
    );

    function automatic int lowest(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) begin
            if (r[i]) return i;
        end
        return -1;
    endfunction

    function automatic logic [N-1:0] vec_of(input int o);
        return (o < 0) ? '0 : (N'(1) << o);
    endfunction

    task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Called at a falling edge; applies r, lets one rising edge pass, checks.
    task automatic step(input logic [N-1:0] r);
        string tag;
        int    prev;
        prev = model;
        req  = r;
        @(posedge clk);
        #1;
        if (prev < 0) begin
            model = lowest(r);
            tag   = (r == '0) ? "R4 idle-stay" : "R3 idle-pick";
        end else if (r[prev]) begin
            tag = "R5 hold";
        end else begin
            model = lowest(r);
            tag   = (r == '0) ? "R7 release-idle" : "R6 handover";
        end
        @(negedge clk);
        check(tag, gnt, vec_of(model));
        check("R2 onehot0", {{(N-1){1'b0}}, $onehot0(gnt)}, {{(N-1){1'b0}}, 1'b1});
        check("R8 grant-needs-req", gnt & ~r, '0);
    endtask

    // Called at a falling edge; one reset edge, then release.
    task automatic do_reset();
        rst_n = 1'b0;
        req   = '1;
        @(negedge clk);
        model = -1;
        check("R1 reset", gnt, '0);
        rst_n = 1'b1;
        req   = '0;
    endtask

    initial begin
        logic [15:0] lfsr;
        @(negedge clk);
        do_reset();

        // Idle: every request pattern.
        for (int p = 0; p < (1 << N); p++) begin
            step(N'(p));
            do_reset();
        end

        // Held by each owner: every next request pattern.
        for (int o = 0; o < N; o++) begin
            for (int p = 0; p < (1 << N); p++) begin
                step(vec_of(o));
                step(N'(p));
                do_reset();
            end
        end

        // Chained hand-overs: higher rank arrives late, then releases cascade.
        step(4'b1000);
        step(4'b1111);
        step(4'b0111);
        step(4'b0110);
        step(4'b0100);
        step(4'b0000);

        // Reset in the middle of a hold.
        step(4'b0010);
        do_reset();

        // Pseudo-random patterns, biased to keep the owner requesting.
        lfsr = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            r = lfsr[N-1:0];
            if (model >= 0 && lfsr[9:8] != 2'b00) r[model] = 1'b1;
            step(r);
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog (all requirements) actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule